// File: doc/BRIEF.md
# Transaction Fault Logger with Interrupt Control

This block records the attributes of one faulting bus transaction and turns the event into an interrupt request. Detection happens upstream. The detector presents a one-cycle strobe, `exc_valid`, together with the address, route, attribute flags, privilege ID and byte count of the failed access. The logger copies these into four read-only log words and sets a pending flag. While that flag is set, later faults are dropped, so the first fault stays on record until software deals with it.

Software reaches the block through a simple 32-bit register bus with 12-bit offsets.
- Read data is combinational and is qualified by `reg_rd`.
- Pending and interrupt-enable each have their own set register and their own clear register. Writing a 1 acts on the flag; writing a 0 has no effect.
- Reading the last log word clears the pending flag, so a handler that walks the log from first word to last acknowledges the fault as it goes.

Two interrupt outputs are provided. The level output simply reflects pending AND enabled AND not masked. The pulse output fires once when that level condition rises. It then stays silent until software writes the end-of-interrupt register.

Top module: `fault_log_irq`

## Requirements
- R1: When `exc_valid` is high, logging is enabled and pending is clear, the fault is captured and the log words read as follows:
  - 0x82C returns address bits 31:0.
  - 0x830 returns address bits 47:32 in bits 15:0.
  - 0x834 returns the route in bits 27:16, the flags in bits 13:8 and the privilege ID in bits 7:0. Flag input bit 5 (write) maps to bit 13, and so on down to input bit 0 (secure), which maps to bit 8.
  - 0x838 returns the byte count in bits 9:0.
  - All other bits read 0.
- R2: A capture sets pending; while pending is set, further faults leave all log words unchanged.
- R3: Control register 0x820 holds two bits, and reads back as written in bits 1:0.
  - Bit 0 set disables logging: faults change neither the log nor pending.
- R4: A read of 0x838 clears pending. Reads of the other log words leave pending unchanged.
- R5: Pending is controlled by bit 0 of two write registers, and reads back on bit 0 of both.
  - Writing bit 0 = 1 at 0x840 sets pending.
  - Writing bit 0 = 1 at 0x844 clears pending.
  - A write with bit 0 = 0 at either offset has no effect.
  - If a set and a clear of pending occur in the same cycle, the set wins.
- R6: The interrupt enable is controlled by bit 0 of two write registers, and reads back on bit 0 of both.
  - Writing bit 0 = 1 at 0x848 sets the enable.
  - Writing bit 0 = 1 at 0x84C clears the enable.
  - A write with bit 0 = 0 at either offset has no effect.
- R7: `irq_level` is high exactly when pending and enable are both set and control bit 1 (interrupt disable) is clear.
- R8: `irq_pulse` is high for one cycle when the level condition rises while the pulse is armed. After firing, the pulse is disarmed, and later rises of the level condition produce no pulse.
- R9: Any write to 0x850 re-arms the pulse. Such a write has no effect on `irq_level`.
- R10: Offset 0x804 holds an 8-bit destination ID. It is written from bits 7:0, reads back in bits 7:0 with zero above, and resets to 0.
- R11: After reset the following hold:
  - Log words, pending, enable and both control bits are 0, and the pulse is armed.
  - `reg_rdata` is 0 when `reg_rd` is low.
  - Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | One-cycle fault strobe |
| exc_addr | input | 48 | Faulting address |
| exc_route | input | 12 | Route identifier of the access |
| exc_flags | input | 6 | Write, read, debug, cacheable, privileged, secure (bit 5 down to 0) |
| exc_priv_id | input | 8 | Privilege ID of the initiator |
| exc_bytes | input | 10 | Byte count of the access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| irq_level | output | 1 | Level interrupt |
| irq_pulse | output | 1 | One-cycle pulse interrupt |

## Verification
The assertions check, on every cycle, the effects that follow a single register update:
- a fault arriving while pending is set, or while logging is disabled, leaves the record unchanged;
- capture, set writes and clear writes drive pending and enable to the required value on the next cycle;
- the pulse never lasts two cycles and never appears without the level;
- the destination ID takes the written byte.

Some behaviour depends on the whole history of the block and only the bench scenarios show it:
- the exact field placement in the log words;
- that the first fault survives later ones;
- that a read of the last word acknowledges the fault;
- that the pulse stays silent without an end-of-interrupt write and returns after one.

A behavioural reference model, compared on every clock against mixed random traffic, covers interleavings the directed steps do not reach.

// File: rtl/flog_pkg.sv
package flog_pkg;
    localparam int BUS_W     = 32;
    localparam int OFS_W     = 12;
    localparam int ADDR_W    = 48;
    localparam int ADDR_LO_W = 32;
    localparam int ADDR_HI_W = ADDR_W - ADDR_LO_W;
    localparam int ROUTE_W   = 12;
    localparam int NFLAG     = 6;
    localparam int PID_W     = 8;
    localparam int BCNT_W    = 10;
    localparam int DEST_W    = 8;
    localparam int LOG_WORDS = 4;
    localparam int IDX_W     = $clog2(LOG_WORDS);
    localparam int ROUTE_LSB = 16;
    localparam int FLAG_LSB  = 8;

    localparam logic [OFS_W-1:0] OFS_DEST     = 12'h804;
    localparam logic [OFS_W-1:0] OFS_CTRL     = 12'h820;
    localparam logic [OFS_W-1:0] OFS_LOG_BASE = 12'h82C;
    localparam logic [OFS_W-1:0] OFS_LOG_LAST = OFS_LOG_BASE + OFS_W'(4 * (LOG_WORDS - 1));
    localparam logic [OFS_W-1:0] OFS_PEND_SET = 12'h840;
    localparam logic [OFS_W-1:0] OFS_PEND_CLR = 12'h844;
    localparam logic [OFS_W-1:0] OFS_EN_SET   = 12'h848;
    localparam logic [OFS_W-1:0] OFS_EN_CLR   = 12'h84C;
    localparam logic [OFS_W-1:0] OFS_EOI      = 12'h850;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [ROUTE_W-1:0] route;
        logic [NFLAG-1:0]   flags;
        logic [PID_W-1:0]   pid;
        logic [BCNT_W-1:0]  bcnt;
    } flog_rec_t;

    typedef struct packed {
        logic pend_set;
        logic pend_clr;
        logic en_set;
        logic en_clr;
        logic eoi;
        logic rd_last;
    } flog_cmd_t;

    typedef struct packed {
        logic irq_off;
        logic log_off;
    } flog_ctl_t;

    function automatic logic [BUS_W-1:0] log_word(flog_rec_t r, logic [IDX_W-1:0] idx);
        logic [BUS_W-1:0] w;
        w = '0;
        case (idx)
            2'd0: w[ADDR_LO_W-1:0] = r.addr[ADDR_LO_W-1:0];
            2'd1: w[ADDR_HI_W-1:0] = r.addr[ADDR_W-1:ADDR_LO_W];
            2'd2: begin
                w[ROUTE_LSB +: ROUTE_W] = r.route;
                w[FLAG_LSB +: NFLAG]    = r.flags;
                w[PID_W-1:0]            = r.pid;
            end
            default: w[BCNT_W-1:0] = r.bcnt;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/flog_capture.sv
module flog_capture
    import flog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      exc_valid,
    input  flog_rec_t exc_in,
    input  logic      log_off,
    input  logic      pend,
    output flog_rec_t rec,
    output logic      capture
);
    assign capture = exc_valid && !log_off && !pend;

    always_ff @(posedge clk) begin
        if (rst)
            rec <= '0;
        else if (capture)
            rec <= exc_in;
    end

    // R2: a fault seen while pending leaves the record untouched
    p_drop_while_pend_r2: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && pend) |=> $stable(rec));

    // R3: logging disabled means the record never changes
    p_no_log_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && log_off) |=> $stable(rec));
endmodule

// File: rtl/flog_irq.sv
module flog_irq
    import flog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  flog_cmd_t cmd,
    input  logic      irq_off,
    output logic      pend,
    output logic      en,
    output logic      irq_level,
    output logic      irq_pulse
);
    logic armed;
    logic level_d;

    assign irq_level = pend && en && !irq_off;
    assign irq_pulse = armed && irq_level && !level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            en      <= 1'b0;
            armed   <= 1'b1;
            level_d <= 1'b0;
        end else begin
            if (capture || cmd.pend_set)
                pend <= 1'b1;
            else if (cmd.pend_clr || cmd.rd_last)
                pend <= 1'b0;

            if (cmd.en_set)
                en <= 1'b1;
            else if (cmd.en_clr)
                en <= 1'b0;

            if (cmd.eoi)
                armed <= 1'b1;
            else if (irq_pulse)
                armed <= 1'b0;

            level_d <= irq_level;
        end
    end

    // R2: capture leaves pending set
    p_capture_pends_r2: assert property (@(posedge clk) disable iff (rst)
        capture |=> pend);

    // R4: read of the last log word acknowledges when nothing sets pend
    p_rd_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_last && !capture && !cmd.pend_set) |=> !pend);

    // R5: explicit set and clear of pending
    p_pend_set_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.pend_set |=> pend);
    p_pend_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.pend_clr && !capture && !cmd.pend_set) |=> !pend);

    // R6: explicit set and clear of enable
    p_en_set_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.en_set |=> en);
    p_en_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.en_clr && !cmd.en_set) |=> !en);

    // R8: the pulse lasts one cycle and only accompanies the level
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);
    p_pulse_has_level_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_level);

    // R8: after a pulse without re-arm, no further pulse next cycle onward
    p_disarm_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && !cmd.eoi) |=> !armed);
endmodule

// File: rtl/flog_regif.sv
module flog_regif
    import flog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    input  flog_rec_t         rec,
    input  logic              pend,
    input  logic              en,
    output flog_cmd_t         cmd,
    output flog_ctl_t         ctl,
    output logic [BUS_W-1:0]  reg_rdata
);
    logic [DEST_W-1:0] dest_id;
    logic [BUS_W-1:0]  words [LOG_WORDS];
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[BUS_W-1:DEST_W];

    for (genvar g = 0; g < LOG_WORDS; g++) begin : g_word
        assign words[g] = log_word(rec, IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_id <= '0;
            ctl     <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_DEST)
                dest_id <= reg_wdata[DEST_W-1:0];
            if (reg_addr == OFS_CTRL) begin
                ctl.log_off <= reg_wdata[0];
                ctl.irq_off <= reg_wdata[1];
            end
        end
    end

    always_comb begin
        cmd          = '0;
        cmd.pend_set = reg_wr && (reg_addr == OFS_PEND_SET) && reg_wdata[0];
        cmd.pend_clr = reg_wr && (reg_addr == OFS_PEND_CLR) && reg_wdata[0];
        cmd.en_set   = reg_wr && (reg_addr == OFS_EN_SET) && reg_wdata[0];
        cmd.en_clr   = reg_wr && (reg_addr == OFS_EN_CLR) && reg_wdata[0];
        cmd.eoi      = reg_wr && (reg_addr == OFS_EOI);
        cmd.rd_last  = reg_rd && (reg_addr == OFS_LOG_LAST);
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_DEST:                 reg_rdata[DEST_W-1:0] = dest_id;
                OFS_CTRL:                 reg_rdata[1:0] = {ctl.irq_off, ctl.log_off};
                OFS_PEND_SET, OFS_PEND_CLR: reg_rdata[0] = pend;
                OFS_EN_SET, OFS_EN_CLR:   reg_rdata[0] = en;
                default: begin
                    for (int i = 0; i < LOG_WORDS; i++)
                        if (reg_addr == OFS_LOG_BASE + OFS_W'(4 * i))
                            reg_rdata = words[i];
                end
            endcase
        end
    end

    // R10: destination ID takes the written byte
    p_dest_write_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_DEST) |=> (dest_id == $past(reg_wdata[DEST_W-1:0])));

    // R11: idle bus returns zero
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |-> (reg_rdata == '0));
endmodule

// File: rtl/fault_log_irq.sv
module fault_log_irq
    import flog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 exc_valid,
    input  logic [ADDR_W-1:0]    exc_addr,
    input  logic [ROUTE_W-1:0]   exc_route,
    input  logic [NFLAG-1:0]     exc_flags,
    input  logic [PID_W-1:0]     exc_priv_id,
    input  logic [BCNT_W-1:0]    exc_bytes,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic [BUS_W-1:0]     reg_wdata,
    output logic [BUS_W-1:0]     reg_rdata,
    output logic                 irq_level,
    output logic                 irq_pulse
);
    flog_rec_t exc_in;
    flog_rec_t rec;
    flog_cmd_t cmd;
    flog_ctl_t ctl;
    logic      capture;
    logic      pend;
    logic      en;

    always_comb begin
        exc_in.addr  = exc_addr;
        exc_in.route = exc_route;
        exc_in.flags = exc_flags;
        exc_in.pid   = exc_priv_id;
        exc_in.bcnt  = exc_bytes;
    end

    flog_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .exc_valid (exc_valid),
        .exc_in    (exc_in),
        .log_off   (ctl.log_off),
        .pend      (pend),
        .rec       (rec),
        .capture   (capture)
    );

    flog_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .cmd       (cmd),
        .irq_off   (ctl.irq_off),
        .pend      (pend),
        .en        (en),
        .irq_level (irq_level),
        .irq_pulse (irq_pulse)
    );

    flog_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rec       (rec),
        .pend      (pend),
        .en        (en),
        .cmd       (cmd),
        .ctl       (ctl),
        .reg_rdata (reg_rdata)
    );

    // R9: a re-arm write leaves the level output where it was
    p_eoi_level_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd.eoi && !capture && !cmd.pend_set && !cmd.pend_clr && !cmd.en_set
         && !cmd.en_clr && !cmd.rd_last) |=> $stable(irq_level));
endmodule

// File: tb/fault_log_irq_tb.sv
module fault_log_irq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0;
    logic [47:0] exc_addr = '0;
    logic [11:0] exc_route = '0;
    logic [5:0]  exc_flags = '0;
    logic [7:0]  exc_priv_id = '0;
    logic [9:0]  exc_bytes = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_level;
    logic        irq_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fault_log_irq u_dut (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_addr(exc_addr),
        .exc_route(exc_route), .exc_flags(exc_flags), .exc_priv_id(exc_priv_id),
        .exc_bytes(exc_bytes), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_level(irq_level),
        .irq_pulse(irq_pulse)
    );

    // behavioural reference model
    logic [31:0] m_log [4];
    bit m_pend, m_en, m_armed, m_prev, m_logoff, m_irqoff;
    logic [7:0] m_dest;

    function automatic bit m_level();
        return m_pend && m_en && !m_irqoff;
    endfunction

    function automatic logic [31:0] m_rdata();
        if (!reg_rd) return 32'h0;
        case (reg_addr)
            12'h804: return {24'h0, m_dest};
            12'h820: return {30'h0, m_irqoff, m_logoff};
            12'h840, 12'h844: return {31'h0, m_pend};
            12'h848, 12'h84C: return {31'h0, m_en};
            12'h82C: return m_log[0];
            12'h830: return m_log[1];
            12'h834: return m_log[2];
            12'h838: return m_log[3];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(logic [11:0] a);
        case (a)
            12'h82C, 12'h830, 12'h834, 12'h838: return "R1";
            12'h820: return "R3";
            12'h840, 12'h844: return "R5";
            12'h848, 12'h84C: return "R6";
            12'h804: return "R10";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        bit lvl, pul, cap;
        if (rst) begin
            for (int i = 0; i < 4; i++) m_log[i] = 32'h0;
            m_pend = 0; m_en = 0; m_armed = 1; m_prev = 0;
            m_logoff = 0; m_irqoff = 0; m_dest = 8'h0;
        end else begin
            lvl = m_level();
            pul = m_armed && lvl && !m_prev;
            cap = exc_valid && !m_logoff && !m_pend;
            if (cap) begin
                m_log[0] = exc_addr[31:0];
                m_log[1] = {16'h0, exc_addr[47:32]};
                m_log[2] = {4'h0, exc_route, 2'b00, exc_flags, exc_priv_id};
                m_log[3] = {22'h0, exc_bytes};
            end
            if (cap || (reg_wr && reg_addr == 12'h840 && reg_wdata[0])) m_pend = 1;
            else if ((reg_wr && reg_addr == 12'h844 && reg_wdata[0]) ||
                     (reg_rd && reg_addr == 12'h838)) m_pend = 0;
            if (reg_wr && reg_addr == 12'h848 && reg_wdata[0]) m_en = 1;
            else if (reg_wr && reg_addr == 12'h84C && reg_wdata[0]) m_en = 0;
            if (reg_wr && reg_addr == 12'h850) m_armed = 1;
            else if (pul) m_armed = 0;
            m_prev = lvl;
            if (reg_wr && reg_addr == 12'h820) begin
                m_logoff = reg_wdata[0];
                m_irqoff = reg_wdata[1];
            end
            if (reg_wr && reg_addr == 12'h804) m_dest = reg_wdata[7:0];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7", {31'h0, irq_level}, {31'h0, m_level()});
            chk("R8", {31'h0, irq_pulse}, {31'h0, m_armed && m_level() && !m_prev});
            chk(rd_tag(reg_addr), reg_rdata, m_rdata());
        end
    end

    task automatic clear_in();
        exc_valid = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #2; clear_in(); end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(posedge clk); #2; clear_in();
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2; clear_in();
    endtask

    task automatic bus_rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #2; clear_in();
        reg_rd = 1; reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
        @(posedge clk); #2; clear_in();
    endtask

    task automatic fault(logic [47:0] a, logic [11:0] r, logic [5:0] f, logic [7:0] p, logic [9:0] b);
        @(posedge clk); #2; clear_in();
        exc_valid = 1; exc_addr = a; exc_route = r; exc_flags = f; exc_priv_id = p; exc_bytes = b;
        @(posedge clk); #2; clear_in();
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R11: reset state
        bus_rd(12'h82C, 32'h0, "R11");
        bus_rd(12'h838, 32'h0, "R11");
        bus_rd(12'h840, 32'h0, "R11");
        bus_rd(12'h848, 32'h0, "R11");
        bus_rd(12'h900, 32'h0, "R11");
        #1 chk("R11", {31'h0, irq_level}, 32'h0);
        // R10: destination ID
        bus_wr(12'h804, 32'hFFFF_FFA5);
        bus_rd(12'h804, 32'h0000_00A5, "R10");
        // R1: capture and field placement
        fault(48'hABCD_1234_5678, 12'h9C3, 6'b101001, 8'h5E, 10'h2F1);
        bus_rd(12'h82C, 32'h1234_5678, "R1");
        bus_rd(12'h830, 32'h0000_ABCD, "R1");
        bus_rd(12'h834, 32'h09C3_295E, "R1");
        bus_rd(12'h840, 32'h1, "R2");
        // R2: second fault dropped
        fault(48'h1111_2222_3333, 12'h123, 6'b010110, 8'h77, 10'h001);
        bus_rd(12'h82C, 32'h1234_5678, "R2");
        bus_rd(12'h830, 32'h0000_ABCD, "R2");
        // R4: only the last word acknowledges
        bus_rd(12'h834, 32'h09C3_295E, "R4");
        bus_rd(12'h840, 32'h1, "R4");
        bus_rd(12'h838, 32'h0000_02F1, "R4");
        bus_rd(12'h844, 32'h0, "R4");
        // R3: logging disabled
        bus_wr(12'h820, 32'h1);
        bus_rd(12'h820, 32'h1, "R3");
        fault(48'h0000_DEAD_BEEF, 12'h001, 6'b000001, 8'h01, 10'h004);
        bus_rd(12'h840, 32'h0, "R3");
        bus_rd(12'h82C, 32'h1234_5678, "R3");
        bus_wr(12'h820, 32'h0);
        // R5 / R6: write-one semantics
        bus_wr(12'h840, 32'hFFFF_FFFE);
        bus_rd(12'h840, 32'h0, "R5");
        bus_wr(12'h848, 32'h1);
        bus_rd(12'h84C, 32'h1, "R6");
        bus_wr(12'h84C, 32'h0);
        bus_rd(12'h848, 32'h1, "R6");
        #1 chk("R7", {31'h0, irq_level}, 32'h0);
        // R8: first rise fires the pulse
        bus_wr(12'h840, 32'h1);
        #1 chk("R8", {31'h0, irq_pulse}, 32'h1);
        chk("R7", {31'h0, irq_level}, 32'h1);
        @(posedge clk); #3 chk("R8", {31'h0, irq_pulse}, 32'h0);
        // R7: interrupt disable masks the level
        bus_wr(12'h820, 32'h2);
        #1 chk("R7", {31'h0, irq_level}, 32'h0);
        bus_wr(12'h820, 32'h0);
        #1 chk("R8", {31'h0, irq_pulse}, 32'h0);
        chk("R7", {31'h0, irq_level}, 32'h1);
        // R9: re-arm leaves the level alone and no rise means no pulse
        bus_wr(12'h850, 32'h0000_0001);
        #1 chk("R9", {31'h0, irq_level}, 32'h1);
        chk("R9", {31'h0, irq_pulse}, 32'h0);
        bus_wr(12'h844, 32'h1);
        bus_rd(12'h840, 32'h0, "R5");
        bus_wr(12'h840, 32'h1);
        #1 chk("R9", {31'h0, irq_pulse}, 32'h1);
        // R8: without re-arm a new rise stays silent
        bus_wr(12'h844, 32'h1);
        bus_wr(12'h840, 32'h1);
        #1 chk("R8", {31'h0, irq_pulse}, 32'h0);
        bus_wr(12'h84C, 32'h1);
        bus_rd(12'h848, 32'h0, "R6");
        // mixed random traffic, compared every clock
        for (int k = 0; k < 600; k++) begin
            logic [11:0] alist [11];
            alist = '{12'h804, 12'h820, 12'h82C, 12'h830, 12'h834, 12'h838,
                      12'h840, 12'h844, 12'h848, 12'h84C, 12'h850};
            @(posedge clk); #2; clear_in();
            exc_valid   = ($urandom % 4) == 0;
            exc_addr    = {$urandom, $urandom};
            exc_route   = 12'($urandom);
            exc_flags   = 6'($urandom);
            exc_priv_id = 8'($urandom);
            exc_bytes   = 10'($urandom);
            reg_addr    = alist[$urandom % 11];
            reg_wdata   = (reg_addr == 12'h820) ? ($urandom % 2) : $urandom;
            reg_wr      = ($urandom % 3) == 0;
            reg_rd      = !reg_wr && (($urandom % 2) == 0);
        end
        idle(2);
        // R11: reset restores the idle state
        @(posedge clk); #2 rst = 1;
        idle(2);
        #0 rst = 0;
        bus_rd(12'h82C, 32'h0, "R11");
        bus_rd(12'h820, 32'h0, "R11");
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
        $finish;
    end
endmodule